// File: doc/BRIEF.md
# Serial Frame Acquisition and Alarm Unit

This block locks onto the byte and frame boundary of a serial SONET/SDH line stream. Line bits arrive one per cycle qualified by a valid strobe. A 48-bit history window is compared against a framing pattern centred on the transition from the 0xF6 run (A1) to the 0x28 run (A2). The length of the compared pattern can be selected. Once a candidate is confirmed at frame spacing, a single bit-position counter defines byte boundaries and the frame start. The aligned byte stream leaves with a valid strobe and a start-of-frame marker.

While aligned, the pattern is checked once per frame. Each miss raises a one-cycle frame error. Runs of misses raise a severely-errored-frame alarm, and a persistent severely-errored-frame condition raises loss of frame. Reframing is started either by a control pulse or, when enabled, automatically by the severely-errored-frame alarm. A loss-of-signal input overrides everything.

The line cannot be stalled, so neither stream has a ready signal. Input bits are consumed on every cycle with `in_valid` high and ignored otherwise. The consumer must accept every output byte in the cycle in which `out_valid` is high.

Top module: `sonet_frame_acq`

## Requirements
- R1: After reset `sef` and `lof` are 1, and `out_valid`, `out_sof` and `frame_err` are 0.
- R2: `pat_mode` selects which pattern is compared. 0 compares 12 bits: 0xD8A, the last 6 bits of the final A1 followed by the first 6 bits of the first A2. 1 compares 24 bits: 0x6F6282. 2 or 3 compares 48 bits: three 0xF6 bytes followed by three 0x28 bytes. Bits are first-received MSB first.
- R3: Alignment, which is `sef` falling from reset or from a reframe, is declared only after a second matching pattern has been seen exactly one frame (FRAME_BYTES×8 valid bits) after the first.
- R4: When aligned, frame byte 0 is the byte that begins 24 bits after the A1/A2 transition, which is the byte after the third A2. It is output with `out_sof`=1. `out_sof` is never high without `out_valid`.
- R5: When aligned, each expected pattern position that does not match gives a one-cycle `frame_err` pulse. There is none during loss of signal or resync.
- R6: `sef` rises only on the 4th consecutive errored pattern, on resync, or on loss of signal. Once aligned, it clears after 2 consecutive correct patterns.
- R7: When `auto_reframe`=1, a raised `sef` sends the block back to hunting and it realigns to a shifted stream. When it is 0, the old alignment is held and `sef` stays high.
- R8: A `resync` pulse raises `sef` and restarts the hunt. The block then realigns after two patterns.
- R9: `lof` rises after `sef` has been high for LOF_FRAMES frame periods. It falls after `sef` has been low for LOF_FRAMES frame periods.
- R10: In the cycle after `los` is sampled high, `sef` and `lof` are 1 and any output byte is 0x00.
- R11: Cycles with `in_valid`=0 change neither alignment nor alarms, and no byte is output for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | `in_bit` carries a line bit this cycle |
| in_bit | input | 1 | Serial line bit |
| pat_mode | input | 2 | Pattern length select (0:12, 1:24, else 48 bits) |
| auto_reframe | input | 1 | Reframe automatically on `sef` |
| resync | input | 1 | Manual reframe request |
| los | input | 1 | Loss of signal |
| out_valid | output | 1 | Aligned byte present |
| out_data | output | 8 | Aligned byte |
| out_sof | output | 1 | Byte is frame byte 0 |
| frame_err | output | 1 | Pattern miss at the expected position |
| sef | output | 1 | Severely-errored-frame alarm |
| lof | output | 1 | Loss-of-frame alarm |

## Verification
The hardest state to reach is a live reframe: an aligned stream whose phase moves under the block. The bench reaches it by inserting three extra bits between frames. The old boundary then misses four times in a row, and the pattern must be found again at the new phase. This is run with automatic reframing, and again with manual reframing followed by a resync pulse. Pattern selectivity is shown by frames whose A1/A2 run has been trimmed. Each mode must lock only on the trims its length tolerates.

// File: rtl/fa_pkg.sv
`timescale 1ns/1ps
package fa_pkg;
  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_PRESYNC = 2'd1,
    ST_SYNC    = 2'd2
  } fa_state_e;

  localparam int unsigned WIN_W = 48;
  localparam logic [47:0] PAT_LONG  = 48'hF6F6F6_282828;
  localparam logic [23:0] PAT_MID   = 24'h6F6_282;
  localparam logic [11:0] PAT_SHORT = 12'hD8A;

  // bits between the end of the compared window and frame byte 0
  function automatic int unsigned tail_lag(input logic [1:0] mode);
    case (mode)
      2'd0:    return 18;
      2'd1:    return 12;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/fa_history.sv
`timescale 1ns/1ps
module fa_history #(
  parameter int unsigned WIN_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             bit_in,
  output logic [WIN_W-1:0] win
);
  logic [WIN_W-2:0] hist_q;

  assign win = {hist_q, bit_in};

  always_ff @(posedge clk) begin
    if (!rst_n)       hist_q <= '0;
    else if (bit_vld) hist_q <= win[WIN_W-2:0];
  end
endmodule

// File: rtl/fa_matcher.sv
`timescale 1ns/1ps
module fa_matcher
  import fa_pkg::*;
(
  input  logic [1:0]       mode,
  input  logic [WIN_W-1:0] win,
  output logic             hit
);
  always_comb begin
    case (mode)
      2'd0:    hit = (win[11:0] == PAT_SHORT);
      2'd1:    hit = (win[23:0] == PAT_MID);
      default: hit = (win[47:0] == PAT_LONG);
    endcase
  end
endmodule

// File: rtl/fa_sync_fsm.sv
`timescale 1ns/1ps
module fa_sync_fsm
  import fa_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 311040,
  parameter int unsigned ERR_SET    = 4,
  parameter int unsigned GOOD_CLR   = 2,
  localparam int unsigned POS_W     = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             hit,
  input  logic [1:0]       mode,
  input  logic             auto_rf,
  input  logic             resync,
  input  logic             los,
  output fa_state_e        state_o,
  output logic [POS_W-1:0] pos_o,
  output logic             sef_o,
  output logic             frerr_o,
  output logic             wrap_o
);
  localparam int unsigned ERR_W  = $clog2(ERR_SET + 1);
  localparam int unsigned GOOD_W = $clog2(GOOD_CLR + 1);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);

  fa_state_e         state_q;
  logic [POS_W-1:0]  pos_q, pos_inc, chk_pos, chk_nxt;
  logic [ERR_W-1:0]  errc_q;
  logic [GOOD_W-1:0] goodc_q;
  logic              sef_q, frerr_q, at_chk;

  assign chk_pos = POS_W'(FRAME_BITS - 1 - tail_lag(mode));
  assign chk_nxt = (chk_pos == LAST) ? '0 : chk_pos + 1'b1;
  assign pos_inc = (pos_q == LAST) ? '0 : pos_q + 1'b1;
  assign at_chk  = (pos_q == chk_pos);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      pos_q   <= '0;
      errc_q  <= '0;
      goodc_q <= '0;
      sef_q   <= 1'b1;
      frerr_q <= 1'b0;
    end else begin
      frerr_q <= 1'b0;
      if (los || resync || (state_q == ST_SYNC && auto_rf && sef_q)) begin
        state_q <= ST_HUNT;
        errc_q  <= '0;
        goodc_q <= '0;
        if (los || resync) sef_q <= 1'b1;
        if (bit_vld) pos_q <= pos_inc;
      end else if (bit_vld) begin
        case (state_q)
          ST_HUNT: begin
            if (hit) begin
              state_q <= ST_PRESYNC;
              pos_q   <= chk_nxt;
            end else begin
              pos_q <= pos_inc;
            end
          end
          ST_PRESYNC: begin
            pos_q <= pos_inc;
            if (at_chk) begin
              if (hit) begin
                state_q <= ST_SYNC;
                sef_q   <= 1'b0;
                errc_q  <= '0;
                goodc_q <= '0;
              end else begin
                state_q <= ST_HUNT;
              end
            end
          end
          ST_SYNC: begin
            pos_q <= pos_inc;
            if (at_chk) begin
              if (!hit) begin
                frerr_q <= 1'b1;
                goodc_q <= '0;
                if (errc_q != ERR_W'(ERR_SET)) errc_q <= errc_q + 1'b1;
                if (errc_q >= ERR_W'(ERR_SET - 1)) sef_q <= 1'b1;
              end else begin
                errc_q <= '0;
                if (sef_q) begin
                  if (goodc_q >= GOOD_W'(GOOD_CLR - 1)) begin
                    sef_q   <= 1'b0;
                    goodc_q <= '0;
                  end else begin
                    goodc_q <= goodc_q + 1'b1;
                  end
                end
              end
            end
          end
          default: state_q <= ST_HUNT;
        endcase
      end
    end
  end

  assign state_o = state_q;
  assign pos_o   = pos_q;
  assign sef_o   = sef_q;
  assign frerr_o = frerr_q;
  assign wrap_o  = bit_vld && (pos_q == LAST);
endmodule

// File: rtl/fa_lof_timer.sv
`timescale 1ns/1ps
module fa_lof_timer #(
  parameter int unsigned LOF_FRAMES = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sef,
  input  logic los,
  output logic lof_o
);
  localparam int unsigned CNT_W = $clog2(LOF_FRAMES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             lof_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lof_q <= 1'b1;
    end else if (los) begin
      cnt_q <= '0;
      lof_q <= 1'b1;
    end else if (tick) begin
      if (sef == lof_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_W'(LOF_FRAMES - 1)) begin
        cnt_q <= '0;
        lof_q <= ~lof_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign lof_o = lof_q;
endmodule

// File: rtl/sonet_frame_acq.sv
`timescale 1ns/1ps
module sonet_frame_acq
  import fa_pkg::*;
#(
  parameter int unsigned FRAME_BYTES = 38880,
  parameter int unsigned LOF_FRAMES  = 24,
  parameter int unsigned ERR_SET     = 4,
  parameter int unsigned GOOD_CLR    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_bit,
  input  logic [1:0] pat_mode,
  input  logic       auto_reframe,
  input  logic       resync,
  input  logic       los,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       frame_err,
  output logic       sef,
  output logic       lof
);
  localparam int unsigned FRAME_BITS = FRAME_BYTES * 8;
  localparam int unsigned POS_W      = $clog2(FRAME_BITS);

  logic [WIN_W-1:0] win;
  logic             hit, wrap, sef_int;
  fa_state_e        state;
  logic [POS_W-1:0] pos;

  fa_history #(.WIN_W(WIN_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .bit_vld(in_valid), .bit_in(in_bit), .win(win)
  );

  fa_matcher u_match (.mode(pat_mode), .win(win), .hit(hit));

  fa_sync_fsm #(
    .FRAME_BITS(FRAME_BITS), .ERR_SET(ERR_SET), .GOOD_CLR(GOOD_CLR)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .bit_vld(in_valid), .hit(hit), .mode(pat_mode),
    .auto_rf(auto_reframe), .resync(resync), .los(los),
    .state_o(state), .pos_o(pos), .sef_o(sef_int), .frerr_o(frame_err),
    .wrap_o(wrap)
  );

  fa_lof_timer #(.LOF_FRAMES(LOF_FRAMES)) u_lof (
    .clk(clk), .rst_n(rst_n), .tick(wrap), .sef(sef_int), .los(los),
    .lof_o(lof)
  );

  assign sef = sef_int;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
    end else begin
      out_valid <= in_valid && (pos[2:0] == 3'd7);
      out_data  <= los ? 8'h00 : win[7:0];
      out_sof   <= in_valid && !los && (state == ST_SYNC) &&
                   (pos == POS_W'(7));
    end
  end
endmodule

// File: rtl/fa_checker.sv
`timescale 1ns/1ps
module fa_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       los,
  input logic       resync,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_sof,
  input logic       frame_err,
  input logic       sef,
  input logic       lof
);
  a_r10_los_forces: assert property (@(posedge clk) disable iff (!rst_n)
    los |=> (sef && lof && out_data == 8'h00));

  a_r4_sof_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);

  a_r11_byte_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  a_r6_sef_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sef) |-> (frame_err || $past(resync) || $past(los)));

  a_r6_sef_fall_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sef) |-> !frame_err);

  a_r9_lof_after_sef: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lof) |-> (sef || $past(sef)));

  a_r5_no_err_on_override: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !($past(los) || $past(resync)));
endmodule

bind sonet_frame_acq fa_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .los(los), .resync(resync),
  .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
  .frame_err(frame_err), .sef(sef), .lof(lof)
);

// File: tb/sonet_frame_acq_tb.sv
`timescale 1ns/1ps
module sonet_frame_acq_tb;
  localparam int FB = 8;
  localparam int LF = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, in_valid, in_bit, auto_reframe, resync, los;
  logic [1:0] pat_mode;
  logic       out_valid, out_sof, frame_err, sef, lof;
  logic [7:0] out_data;

  sonet_frame_acq #(.FRAME_BYTES(FB), .LOF_FRAMES(LF)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .pat_mode(pat_mode), .auto_reframe(auto_reframe), .resync(resync),
    .los(los), .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .frame_err(frame_err), .sef(sef), .lof(lof)
  );

  int n_chk = 0, n_fail = 0;
  int sof_cnt = 0, frerr_cnt = 0, los_bytes = 0, los_bad = 0;
  logic [7:0] last_sof = 8'h00;
  logic los_cap = 1'b0;
  logic gap = 1'b0;

  always @(posedge clk) los_cap <= los;

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_sof) begin sof_cnt++; last_sof = out_data; end
      if (frame_err) frerr_cnt++;
      if (out_valid && los_cap) begin
        los_bytes++;
        if (out_data != 8'h00) los_bad++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    if (gap) begin @(posedge clk); #1; in_valid = 1'b0; end
    @(posedge clk); #1; in_valid = 1'b1; in_bit = b;
  endtask

  task automatic settle();
    @(posedge clk); #1; in_valid = 1'b0; in_bit = 1'b0;
    @(negedge clk); #1;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  // kind 0 full run, 1 trimmed to 2+2, 2 trimmed to 1+1, 3 no A1
  function automatic logic [7:0] fbyte(input int kind, input int idx);
    logic [7:0] f [8];
    f = '{8'hF6, 8'hF6, 8'hF6, 8'h28, 8'h28, 8'h28, 8'h5A, 8'h3C};
    if (kind == 1) begin f[0] = 8'h00; f[5] = 8'h00; end
    if (kind == 2) begin f[0] = 8'h00; f[1] = 8'h00; f[4] = 8'h00; f[5] = 8'h00; end
    if (kind == 3) begin f[0] = 8'h00; f[1] = 8'h00; f[2] = 8'h00; end
    return f[idx];
  endfunction

  task automatic send_frame(input int kind);
    for (int i = 0; i < FB; i++) send_byte(fbyte(kind, i));
  endtask

  task automatic frames(input int kind, input int n);
    for (int i = 0; i < n; i++) send_frame(kind);
  endtask

  task automatic do_reset();
    in_valid = 1'b0; in_bit = 1'b0; resync = 1'b0; los = 1'b0; gap = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int e0, s0;
    pat_mode = 2'd2; auto_reframe = 1'b0;
    do_reset();
    // R1 reset state
    chk(sef == 1'b1, "R1 sef", sef, 1);
    chk(lof == 1'b1, "R1 lof", lof, 1);
    chk(out_valid == 1'b0 && out_sof == 1'b0, "R1 out_valid/out_sof", out_valid, 0);
    chk(frame_err == 1'b0, "R1 frame_err", frame_err, 0);

    // R2 R3 R4 R11: sweep of modes against trimmed patterns
    for (int mode = 0; mode < 3; mode++) begin
      for (int kind = 0; kind < 4; kind++) begin
        bit exp_lock;
        exp_lock = (kind == 0) || (kind == 1 && mode <= 1) || (kind == 2 && mode == 0);
        do_reset();
        pat_mode = 2'(mode);
        gap = (kind == 1);
        e0 = frerr_cnt;
        repeat (mode * 3 + kind) send_bit(1'b0);
        send_frame(kind); settle();
        chk(sef == 1'b1, "R3 one pattern", sef, 1);
        send_frame(kind); settle();
        chk(sef == !exp_lock, gap ? "R2 R11 lock" : "R2 lock", sef, !exp_lock);
        s0 = sof_cnt;
        send_frame(kind); settle();
        if (exp_lock)
          chk(sof_cnt == s0 + 1 && last_sof == 8'h5A, "R4 byte0",
              last_sof, 8'h5A);
        chk(frerr_cnt == e0, "R5 no error while clean", frerr_cnt - e0, 0);
      end
    end

    // R5 R6 R9: manual mode error runs
    do_reset(); pat_mode = 2'd2; auto_reframe = 1'b0;
    frames(0, 6); settle();
    chk(sef == 1'b0 && lof == 1'b0, "R9 lof clears in frame", lof, 0);
    e0 = frerr_cnt;
    frames(3, 3); settle();
    chk(sef == 1'b0, "R6 three misses", sef, 0);
    chk(frerr_cnt - e0 == 3, "R5 pulses", frerr_cnt - e0, 3);
    frames(3, 1); settle();
    chk(sef == 1'b1, "R6 fourth miss", sef, 1);
    chk(frerr_cnt - e0 == 4, "R5 pulses", frerr_cnt - e0, 4);
    frames(3, 2); settle();
    chk(lof == 1'b0, "R9 lof not yet", lof, 0);
    frames(3, 1); settle();
    chk(lof == 1'b1, "R9 lof set", lof, 1);
    frames(0, 1); settle();
    chk(sef == 1'b1, "R6 one good", sef, 1);
    frames(0, 1); settle();
    chk(sef == 1'b0, "R6 two good", sef, 0);
    frames(0, 2); settle();
    chk(lof == 1'b1, "R9 lof held", lof, 1);
    frames(0, 1); settle();
    chk(lof == 1'b0, "R9 lof cleared", lof, 0);

    // R7: automatic reframe after a 3-bit slip
    do_reset(); pat_mode = 2'd1; auto_reframe = 1'b1;
    frames(0, 3); settle();
    chk(sef == 1'b0, "R7 initial lock", sef, 0);
    e0 = frerr_cnt;
    repeat (3) send_bit(1'b0);
    frames(0, 8); settle();
    chk(sef == 1'b0, "R7 auto relock", sef, 0);
    chk(frerr_cnt - e0 == 4, "R7 misses before hunt", frerr_cnt - e0, 4);
    chk(last_sof == 8'h5A, "R7 new byte0", last_sof, 8'h5A);

    // R7 manual hold, R8 resync
    do_reset(); pat_mode = 2'd1; auto_reframe = 1'b0;
    frames(0, 3);
    repeat (3) send_bit(1'b0);
    frames(0, 8); settle();
    chk(sef == 1'b1, "R7 manual holds", sef, 1);
    @(posedge clk); #1 resync = 1'b1;
    @(posedge clk); #1 resync = 1'b0;
    s0 = sof_cnt;
    frames(0, 3); settle();
    chk(sef == 1'b0, "R8 relock", sef, 0);
    chk(sof_cnt > s0 && last_sof == 8'h5A, "R8 byte0", last_sof, 8'h5A);

    // R10 loss of signal
    @(posedge clk); #1 los = 1'b1;
    los_bytes = 0; los_bad = 0;
    frames(0, 1); settle();
    chk(sef == 1'b1 && lof == 1'b1, "R10 alarms", {sef, lof}, 3);
    chk(los_bytes == FB, "R10 bytes seen", los_bytes, FB);
    chk(los_bad == 0, "R10 zero data", los_bad, 0);
    @(posedge clk); #1 los = 1'b0;

    // R11 idle cycles leave alignment alone
    do_reset(); pat_mode = 2'd0; auto_reframe = 1'b0;
    frames(0, 3); settle();
    e0 = frerr_cnt;
    repeat (100) begin @(posedge clk); #1 in_valid = 1'b0; end
    s0 = sof_cnt;
    frames(0, 3); settle();
    chk(sef == 1'b0 && frerr_cnt == e0, "R11 idle keeps lock", frerr_cnt - e0, 0);
    chk(sof_cnt - s0 == 3, "R11 frame count", sof_cnt - s0, 3);

    summary();
    $finish;
  end
endmodule